// File: doc/BRIEF.md
# Byte Serial Link Port

This block moves one byte at a time over a synchronous three-wire link: a shift clock, an outgoing data line and an incoming data line. Software loads the byte to send into the data register and then sets the start bit in the control register. While the transfer runs, the data register shifts out its most significant bit first and takes in the incoming bits at its least significant end. When the eighth bit has arrived, the data register holds the received byte. The block then clears its own start bit and pulses an interrupt request.

When the internal clock source is selected, the block does not need a counter of its own. It watches one bit of a free-running system divider that is shared with the rest of the chip. Every change of that bit, rising or falling, is one half of a serial clock period. A control bit picks between a slow rate (a 512-cycle period, divider bit 8) and a fast rate (a 16-cycle period, divider bit 3). With the external clock source selected, the divider does not move the transfer.

Top module: `slp_link_port`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0, `ser_clk_o` is 1, `ser_dout` is 1 and `irq_o` is 0.
- R2: `reg_sel` = 0 selects the data register and `reg_sel` = 1 selects the control register. In the control register, bit 7 is the start/busy bit, bit 1 selects the fast rate and bit 0 selects the internal clock. All other control bits read as 0. `reg_rdata` shows the selected register combinationally.
- R3: Writing the control register with bit 7 set loads a count of 16 half-periods. This also happens when a transfer is already running, so the transfer restarts from its first half-period.
- R4: A half-period occurs in any cycle where the selected divider bit differs from its value in the previous cycle. That is bit 8 in slow mode, so a byte takes 3841 to 4096 cycles after the start. It is bit 3 in fast mode, so a byte takes 121 to 128 cycles. A change of the fast bit takes effect from the next cycle.
- R5: With control bit 0 clear, divider changes leave the shift clock, the data register and the count unchanged.
- R6: With control bit 7 clear, divider changes leave the shift clock and the data register unchanged, and no interrupt is raised.
- R7: Half-periods alternate, starting with a falling phase. The falling phase drives `ser_clk_o` low and puts the data register's bit 7 on `ser_dout`. The rising phase drives `ser_clk_o` high and shifts the register left, taking `ser_din` into bit 0. The byte is therefore sent MSB first and received MSB first.
- R8: On the sixteenth half-period, control bit 7 clears and `irq_o` goes high for exactly one cycle, at the same clock edge. The data register then holds the received byte.
- R9: In a cycle with a register write, a half-period that falls in the same cycle is dropped, and the written value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 data, 1 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| div_i | input | 16 | Free-running system divider value |
| ser_din | input | 1 | Incoming serial data |
| ser_dout | output | 1 | Outgoing serial data |
| ser_clk_o | output | 1 | Serial shift clock (idles high) |
| irq_o | output | 1 | Transfer-complete interrupt pulse |

## Verification
The bench drives the incoming line in three ways: looped back from the outgoing line, looped back inverted, and held at a constant. A design that swaps the shift direction or the phase order receives the wrong byte in these tests, and it also captures the wrong sequence on the outgoing pins. Start-to-interrupt latency is measured in both rates and across a restart in mid-transfer. A design that detects only one edge direction of the divider bit takes twice as long, and a design that ignores a restart finishes early. The bench times a data write so that it lands exactly on a half-period edge, which shows whether a register write takes priority. It also holds the external-clock and disabled cases for several hundred cycles, where any shift or clock toggle shows up as a miscompare against the reference model.

// File: rtl/slp_pkg.sv
// Package: slp_pkg
// Shared constants and types for the serial link port.
// Assumes register data is at least 8 bits wide so that the control bits fit.
package slp_pkg;

    // Register select codes
    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    // Control bit positions (software visible, behaviour depends on them)
    localparam int CTL_START_BIT = 7;
    localparam int CTL_FAST_BIT  = 1;
    localparam int CTL_INTCLK_BIT = 0;

    // Decoded control register state
    typedef struct packed {
        logic start;
        logic fast;
        logic intclk;
    } ctl_t;

endpackage

// File: rtl/slp_tick_gen.sv
// Module: slp_tick_gen
// Derives half-period ticks from a shared free-running divider.
// A tick fires in every cycle where the selected divider bit differs from
// the value it had one cycle earlier (both edge directions count).
// Assumes the divider advances by at most one step per cycle.
module slp_tick_gen #(
    parameter int DIV_W    = 16,
    parameter int SLOW_BIT = 8,
    parameter int FAST_BIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             fast_i,
    input  logic             gate_i,
    output logic             tick_o
);

    localparam logic [DIV_W-1:0] SLOW_MASK = DIV_W'(1) << SLOW_BIT;
    localparam logic [DIV_W-1:0] FAST_MASK = DIV_W'(1) << FAST_BIT;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] sel_mask;
    logic             bit_flip;

    // Hold the previous divider value for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_i;
        end
    end

    // Pick the watched divider bit according to the current rate
    generate
        if (SLOW_BIT == FAST_BIT) begin : g_single_rate
            always_comb sel_mask = SLOW_MASK;
        end else begin : g_dual_rate
            always_comb sel_mask = fast_i ? FAST_MASK : SLOW_MASK;
        end
    endgenerate

    // A half-period tick is any change of the watched bit, qualified by the gate
    always_comb begin
        bit_flip = |((div_q ^ div_i) & sel_mask);
        tick_o   = bit_flip & gate_i;
    end

endmodule

// File: rtl/slp_ctrl.sv
// Module: slp_ctrl
// Control register, half-period counter and completion interrupt.
// Starting a transfer loads HALF_TICKS. Each qualified tick counts it down and
// marks the tick as a falling (even count) or rising (odd count) phase. Reaching zero clears
// the start bit and pulses the interrupt at the same edge.
// Assumes adv_i is already gated by start, internal clock and no-write.
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int HALF_TICKS = 16,
    parameter int CNT_W      = $clog2(HALF_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_i,
    input  ctl_t             ctl_wdata_i,
    input  logic             adv_i,
    output ctl_t             ctl_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fall_o,
    output logic             rise_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HALF_TICKS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    ctl_t             ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;

    // Classify the current tick by the parity of the remaining count
    always_comb begin
        fall_o = adv_i & ~cnt_q[0];
        rise_o = adv_i &  cnt_q[0];
    end

    // Control register, count and single-cycle interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (ctl_wr_i) begin
                ctl_q <= ctl_wdata_i;
                if (ctl_wdata_i.start) begin
                    cnt_q <= CNT_LOAD;
                end
            end else if (adv_i) begin
                cnt_q <= cnt_q - CNT_LAST;
                if (cnt_q == CNT_LAST) begin
                    ctl_q.start <= 1'b0;
                    irq_q       <= 1'b1;
                end
            end
        end
    end

    assign ctl_o = ctl_q;
    assign cnt_o = cnt_q;
    assign irq_o = irq_q;

endmodule

// File: rtl/slp_shifter.sv
// Module: slp_shifter
// Data register with the serial shift path and the pin registers.
// Falling phase: clock low, MSB presented. Rising phase: clock high,
// register shifts left taking the incoming bit. A register write overrides.
// Assumes fall_i and rise_i never assert together.
module slp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr_i,
    input  logic [DATA_W-1:0] data_wdata_i,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic              sdin_i,
    output logic [DATA_W-1:0] data_o,
    output logic              sclk_o,
    output logic              sdout_o
);

    logic [DATA_W-1:0] data_q;
    logic              sclk_q;
    logic              sdout_q;

    // Data register: software write, else shift on the rising phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_wr_i) begin
            data_q <= data_wdata_i;
        end else if (rise_i) begin
            data_q <= {data_q[DATA_W-2:0], sdin_i};
        end
    end

    // Pin registers: clock level per phase, outgoing bit on the falling phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b1;
            sdout_q <= 1'b1;
        end else if (fall_i) begin
            sclk_q  <= 1'b0;
            sdout_q <= data_q[DATA_W-1];
        end else if (rise_i) begin
            sclk_q  <= 1'b1;
        end
    end

    assign data_o  = data_q;
    assign sclk_o  = sclk_q;
    assign sdout_o = sdout_q;

endmodule

// File: rtl/slp_link_port.sv
// Module: slp_link_port
// Top of the byte serial link port: register port, divider-derived shift
// timing, shifter and completion interrupt.
// Assumes DATA_W >= 8 (the control bits live in the low byte) and that
// div_i is a free-running count shared with the rest of the chip.
module slp_link_port
    import slp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 16,
    parameter int SLOW_BIT = 8,
    parameter int FAST_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_clk_o,
    output logic              irq_o
);

    localparam int HALF_TICKS = 2 * DATA_W;
    localparam int CNT_W      = $clog2(HALF_TICKS + 1);

    ctl_t              ctl;
    ctl_t              ctl_wval;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] data_q;
    logic              ctl_wr;
    logic              data_wr;
    logic              tick_gate;
    logic              tick;
    logic              adv;
    logic              fall;
    logic              rise;
    logic              ctl_en;
    logic              ctl_int;

    // Decode register writes and the control fields being written
    always_comb begin
        ctl_wr          = reg_wr_en & (reg_sel == SEL_CTRL);
        data_wr         = reg_wr_en & (reg_sel == SEL_DATA);
        ctl_wval.start  = reg_wdata[CTL_START_BIT];
        ctl_wval.fast   = reg_wdata[CTL_FAST_BIT];
        ctl_wval.intclk = reg_wdata[CTL_INTCLK_BIT];
    end

    // Ticks count only during a transfer with the internal clock selected
    always_comb begin
        tick_gate = ctl.start & ctl.intclk;
        adv       = tick & ~reg_wr_en;
    end

    slp_tick_gen #(
        .DIV_W    (DIV_W),
        .SLOW_BIT (SLOW_BIT),
        .FAST_BIT (FAST_BIT)
    ) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (div_i),
        .fast_i (ctl.fast),
        .gate_i (tick_gate),
        .tick_o (tick)
    );

    slp_ctrl #(
        .HALF_TICKS (HALF_TICKS),
        .CNT_W      (CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr_i    (ctl_wr),
        .ctl_wdata_i (ctl_wval),
        .adv_i       (adv),
        .ctl_o       (ctl),
        .cnt_o       (cnt),
        .fall_o      (fall),
        .rise_o      (rise),
        .irq_o       (irq_o)
    );

    slp_shifter #(
        .DATA_W (DATA_W)
    ) shift_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_wr_i    (data_wr),
        .data_wdata_i (reg_wdata),
        .fall_i       (fall),
        .rise_i       (rise),
        .sdin_i       (ser_din),
        .data_o       (data_q),
        .sclk_o       (ser_clk_o),
        .sdout_o      (ser_dout)
    );

    // Flat copies of control state for observation
    assign ctl_en  = ctl.start;
    assign ctl_int = ctl.intclk;

    // Read mux: control bits placed at their positions, others zero
    always_comb begin
        reg_rdata = '0;
        if (reg_sel == SEL_CTRL) begin
            reg_rdata[CTL_START_BIT]  = ctl.start;
            reg_rdata[CTL_FAST_BIT]   = ctl.fast;
            reg_rdata[CTL_INTCLK_BIT] = ctl.intclk;
        end else begin
            reg_rdata = data_q;
        end
    end

endmodule

// File: rtl/slp_link_port_chk.sv
// Module: slp_link_port_chk
// Temporal checks on the serial link port, attached by bind.
module slp_link_port_chk #(
    parameter int DATA_W     = 8,
    parameter int HALF_TICKS = 16,
    parameter int CNT_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              sel,
    input logic              wstart,
    input logic              en,
    input logic              intclk,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] data,
    input logic              sclk,
    input logic              irq
);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(HALF_TICKS)); // R3
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel && wstart) |=> (cnt == CNT_W'(HALF_TICKS) && en)); // R3
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R8
    AST_IRQ_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !en); // R8
    AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cnt) == CNT_W'(1) && cnt == '0)); // R8
    AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_en) |=> ($stable(data) && $stable(sclk))); // R6
    AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!intclk && !wr_en) |=> ($stable(data) && $stable(sclk) && $stable(cnt))); // R5

endmodule

bind slp_link_port slp_link_port_chk #(
    .DATA_W     (DATA_W),
    .HALF_TICKS (HALF_TICKS),
    .CNT_W      (CNT_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .sel    (reg_sel),
    .wstart (reg_wdata[7]),
    .en     (ctl_en),
    .intclk (ctl_int),
    .cnt    (cnt),
    .data   (data_q),
    .sclk   (ser_clk_o),
    .irq    (irq_o)
);

// File: tb/slp_link_port_tb_top.sv
module slp_link_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        sel = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [15:0] div = 16'h0;
    logic        sd_in = 1'b0;
    logic        sd_out;
    logic        sclk;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int sd_mode = 2;   // 0 loop, 1 inverted loop, 2 const 1, 3 const 0

    // Reference model state
    bit       m_en, m_fast, m_int, m_sclk, m_sdo, m_irq, m_tk;
    bit [7:0] m_data;
    bit [15:0] m_prev;
    int       m_left, m_half;

    // Edge capture of the outgoing line
    bit       prev_sclk = 1'b1;
    bit [7:0] cap;
    int       rises;

    always #4 clk = ~clk;   // 125 MHz

    slp_link_port dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (wr),
        .reg_sel   (sel),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .div_i     (div),
        .ser_din   (sd_in),
        .ser_dout  (sd_out),
        .ser_clk_o (sclk),
        .irq_o     (irq)
    );

    // Behavioural reference of the port, advanced on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_fast = 0; m_int = 0; m_data = 0;
            m_sclk = 1; m_sdo = 1; m_irq = 0; m_left = 0; m_prev = 0;
        end else begin
            m_half = m_fast ? 8 : 256;
            m_tk = ((int'(div ^ m_prev) & m_half) != 0) && m_int && m_en && !wr;
            m_irq = 0;
            if (wr && sel) begin
                m_en = wdata[7]; m_fast = wdata[1]; m_int = wdata[0];
                if (wdata[7]) m_left = 16;
            end else if (wr) begin
                m_data = wdata;
            end
            if (m_tk) begin
                if (m_left % 2 == 0) begin
                    m_sclk = 0; m_sdo = m_data[7];
                end else begin
                    m_sclk = 1; m_data = {m_data[6:0], sd_in};
                end
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_en = 0; m_irq = 1;
                end
            end
            m_prev = div;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] m_read(bit s);
        return s ? {m_en, 5'b0, m_fast, m_int} : m_data;
    endfunction

    // One clock: compare against the model, then advance the divider and data line
    task automatic clk1();
        @(posedge clk);
        #3;
        chk("R7 clk", sclk, m_sclk);
        chk("R7 dout", sd_out, m_sdo);
        chk("R8 irq", irq, m_irq);
        chk("R2 rdata", rdata, m_read(sel));
        if (sclk && !prev_sclk) begin
            cap = {cap[6:0], sd_out};
            rises++;
        end
        prev_sclk = sclk;
        div = div + 16'h1;
        case (sd_mode)
            0: sd_in = sd_out;
            1: sd_in = ~sd_out;
            2: sd_in = 1'b1;
            default: sd_in = 1'b0;
        endcase
        if (!wr) sel = ~sel;
    endtask

    task automatic wr_reg(bit s, bit [7:0] d);
        wr = 1'b1; sel = s; wdata = d;
        clk1();
        wr = 1'b0;
    endtask

    task automatic rd_chk(bit s, bit [7:0] exp, string req);
        sel = s;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic wait_irq(int lim, output int n);
        n = 0;
        for (int i = 0; i < lim; i++) begin
            clk1();
            n++;
            if (irq) break;
        end
    endtask

    task automatic in_range(string req, int v, int lo, int hi);
        n_chk++;
        if (v < lo || v > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, v, lo, hi);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        // R1: reset state
        repeat (3) clk1();
        rd_chk(1'b1, 8'h00, "R1 ctrl");
        rd_chk(1'b0, 8'h00, "R1 data");
        chk("R1 clk", sclk, 1);
        chk("R1 dout", sd_out, 1);
        chk("R1 irq", irq, 0);
        rst_n = 1'b1;
        clk1();

        // R2: register layout
        wr_reg(1'b1, 8'hFF);
        rd_chk(1'b1, 8'h83, "R2 ctrl bits");
        wr_reg(1'b1, 8'h00);
        rd_chk(1'b1, 8'h00, "R2 ctrl clear");
        wr_reg(1'b0, 8'hA5);
        rd_chk(1'b0, 8'hA5, "R2 data");
        repeat (4) clk1();

        // R4/R7/R8: fast loopback, sent byte comes back and is captured MSB first
        sd_mode = 0; rises = 0; cap = 0;
        wr_reg(1'b0, 8'h5C);
        wr_reg(1'b1, 8'h83);
        wait_irq(400, n);
        in_range("R4 fast latency", n, 121, 128);
        chk("R8 irq seen", irq, 1);
        rd_chk(1'b1, 8'h03, "R8 start cleared");
        rd_chk(1'b0, 8'h5C, "R8 loop byte");
        chk("R7 rises", rises, 8);
        chk("R7 msb first", cap, 8'h5C);
        clk1();
        chk("R8 irq one cycle", irq, 0);

        // R7: inverted loop receives the complement
        sd_mode = 1;
        wr_reg(1'b0, 8'h3A);
        wr_reg(1'b1, 8'h83);
        wait_irq(400, n);
        rd_chk(1'b0, 8'hC5, "R7 inverted byte");

        // R4/R8: slow rate with constant-high input
        sd_mode = 2;
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h81);
        repeat (2000) clk1();
        rd_chk(1'b1, 8'h81, "R4 slow still busy");
        wait_irq(3000, n);
        in_range("R4 slow latency", n + 2000, 3841, 4096);
        rd_chk(1'b0, 8'hFF, "R8 slow byte");

        // R5: external clock selected, divider must not advance
        sd_mode = 3; rises = 0;
        wr_reg(1'b0, 8'h96);
        wr_reg(1'b1, 8'h82);
        repeat (600) clk1();
        rd_chk(1'b1, 8'h82, "R5 still pending");
        rd_chk(1'b0, 8'h96, "R5 data held");
        chk("R5 no clock", rises, 0);

        // R6: internal clock but start clear
        wr_reg(1'b1, 8'h03);
        repeat (300) clk1();
        rd_chk(1'b0, 8'h96, "R6 data held");
        chk("R6 clk idle", sclk, 1);
        chk("R6 no irq", irq, 0);

        // R3: restart mid-transfer reloads the count
        sd_mode = 0;
        wr_reg(1'b1, 8'h83);
        repeat (60) clk1();
        wr_reg(1'b1, 8'h83);
        wait_irq(400, n);
        in_range("R3 restart latency", n, 121, 128);

        // R4: switching to fast mid slow transfer takes effect at once
        wr_reg(1'b1, 8'h81);
        repeat (100) clk1();
        wr_reg(1'b1, 8'h83);
        wait_irq(400, n);
        in_range("R4 rate switch", n, 121, 128);

        // R9: data write landing on a tick edge wins
        wr_reg(1'b1, 8'h83);
        repeat (20) clk1();
        while (div[2:0] != 3'b000) clk1();
        wr_reg(1'b0, 8'h66);
        rd_chk(1'b0, 8'h66, "R9 write wins");
        wait_irq(400, n);
        repeat (5) clk1();

        finish_run();
    end

endmodule